// File: doc/BRIEF.md
# Receive Back-Pressure Trigger

This block decides when a MAC receive path has to stop taking new frames. It watches the free-buffer count of several receive channels and the fill level of the shared receive FIFO. A buffer-side trigger fires when any enabled channel's free count drops to or below that channel's threshold. A FIFO-side trigger fires when the fill level reaches or passes a programmable FIFO threshold. Each trigger has its own enable. The FIFO trigger only counts in full-duplex operation.

When either trigger is active, the block raises a receive hold-off. It also asks the transmit side for back-pressure: in half duplex it asserts a forced-collision request for as long as the hold-off lasts. In full duplex it sends a one-cycle pause request when the hold-off begins, and a second pulse, marked as zero-quanta, when the hold-off ends. The hold-off changes only between frames, so a frame already being received is never cut short.

The FIFO threshold is held in a register inside the block. Any value written to it is forced into the range 1 to 66.

Top module: `rx_backpressure_ctl`

## Requirements
- R1: After reset `rx_hold`, `coll_req` and `pause_req` are 0, and the FIFO threshold is 2.
- R2: With `buf_fc_en`=1, the buffer trigger is active when any channel i with `ch_en[i]`=1 has a free count (bits `[i*CNT_W +: CNT_W]` of `ch_free_cnt`) less than or equal to its threshold (same slice of `ch_thresh`).
- R3: A channel with `ch_en[i]`=0 has no effect, and with `buf_fc_en`=0 the buffer counts have no effect.
- R4: With `fifo_fc_en`=1 and `full_duplex`=1, the FIFO trigger is active when `fifo_level` is greater than or equal to the FIFO threshold.
- R5: With `full_duplex`=0, the FIFO level has no effect.
- R6: A write (`fifo_thr_wr`=1) stores `fifo_thr_wdata` clamped to the range 1 to 66: values below 1 are stored as 1 and values above 66 are stored as 66.
- R7: `rx_hold` keeps its value on every clock edge at which `frame_active` is 1.
- R8: `rx_hold` stays 1 until both triggers are inactive. If one trigger clears in the same cycle the other becomes active, the hold-off does not drop.
- R9: In half duplex, `coll_req` follows `rx_hold` and `pause_req` stays 0.
- R10: In full duplex, `coll_req` stays 0, and `pause_req` is a one-cycle pulse with `pause_zero`=0 in the first cycle `rx_hold` is 1.
- R11: In full duplex, `pause_req` is a one-cycle pulse with `pause_zero`=1 in the first cycle after `rx_hold` returns to 0.
- R12: When `frame_active` is 0, a change of a trigger input shows on `rx_hold` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_free_cnt | input | NUM_CH*CNT_W | Free buffer count for each channel, packed |
| ch_thresh | input | NUM_CH*CNT_W | Trigger threshold for each channel, packed |
| ch_en | input | NUM_CH | Channel participates in the buffer trigger |
| buf_fc_en | input | 1 | Enable for the buffer trigger |
| fifo_fc_en | input | 1 | Enable for the FIFO trigger |
| full_duplex | input | 1 | 1 = full duplex (pause), 0 = half duplex (collision) |
| fifo_level | input | OCC_W | Current receive FIFO occupancy |
| fifo_thr_wr | input | 1 | Write strobe for the FIFO threshold |
| fifo_thr_wdata | input | OCC_W | FIFO threshold write value |
| frame_active | input | 1 | A frame is currently being received |
| rx_hold | output | 1 | Receive hold-off |
| coll_req | output | 1 | Forced-collision request (half duplex) |
| pause_req | output | 1 | One-cycle pause frame request (full duplex) |
| pause_zero | output | 1 | Qualifies `pause_req`: 1 = zero-quanta release pause |

## Verification
Two events can land in the same cycle: the buffer trigger releasing and the FIFO trigger engaging. The bench provokes this by clearing the low channel count and raising the FIFO level past its threshold on the same clock edge. It judges the result by requiring that `rx_hold` stays 1 and that no pause pulse of either kind appears in the following cycles. A second coincidence occurs when a trigger flips while a frame is in flight. The bench requires the hold-off to stay frozen until `frame_active` drops, and then to change on the very next edge.

// File: rtl/rxbp_pkg.sv
package rxbp_pkg;

  localparam int unsigned FIFO_THR_MIN = 1;
  localparam int unsigned FIFO_THR_MAX = 66;
  localparam int unsigned FIFO_THR_RST = 2;

  typedef enum logic [1:0] {
    BP_IDLE    = 2'b00,
    BP_HOLDING = 2'b01
  } bp_state_e;

  function automatic int unsigned clamp_range(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/rxbp_buf_cmp.sv
module rxbp_buf_cmp #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*CNT_W-1:0] free_cnt,
  input  logic [NUM_CH*CNT_W-1:0] thresh,
  input  logic [NUM_CH-1:0]       chan_en,
  input  logic                    enable,
  output logic                    trig_q
);

  logic [NUM_CH-1:0] low_hit;
  logic              trig_d;

  // Per-channel compare: a channel is low when free count <= threshold.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [CNT_W-1:0] cnt_v;
    logic [CNT_W-1:0] thr_v;
    assign cnt_v      = free_cnt[g*CNT_W +: CNT_W];
    assign thr_v      = thresh[g*CNT_W +: CNT_W];
    assign low_hit[g] = chan_en[g] & (cnt_v <= thr_v);
  end

  always_comb begin
    trig_d = enable & (|low_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

endmodule

// File: rtl/rxbp_fifo_cmp.sv
module rxbp_fifo_cmp
  import rxbp_pkg::*;
#(
  parameter int unsigned OCC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] level,
  input  logic             thr_wr,
  input  logic [OCC_W-1:0] thr_wdata,
  input  logic             enable,
  input  logic             full_duplex,
  output logic             trig_q
);

  localparam logic [OCC_W-1:0] THR_LO  = OCC_W'(FIFO_THR_MIN);
  localparam logic [OCC_W-1:0] THR_HI  = OCC_W'(FIFO_THR_MAX);
  localparam logic [OCC_W-1:0] THR_RST = OCC_W'(FIFO_THR_RST);

  logic [OCC_W-1:0] thr_q;
  logic [OCC_W-1:0] thr_d;
  logic             thr_ce;
  logic             trig_d;

  always_comb begin
    thr_ce = thr_wr;
    thr_d  = OCC_W'(clamp_range(int'(thr_wdata), int'(THR_LO), int'(THR_HI)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= THR_RST;
    else if (thr_ce) thr_q <= thr_d;
  end

  // Occupancy trigger only counts in full duplex.
  always_comb begin
    trig_d = enable & full_duplex & (level >= thr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

endmodule

// File: rtl/rxbp_hold_ctl.sv
module rxbp_hold_ctl
  import rxbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic buf_trig,
  input  logic fifo_trig,
  input  logic frame_active,
  input  logic full_duplex,
  output logic hold,
  output logic coll,
  output logic pause,
  output logic pause_zero
);

  bp_state_e state_q, state_d;
  logic      hold_ce;
  logic      any_trig;
  logic      coll_d;
  logic      pause_d;
  logic      zero_d;

  always_comb begin
    any_trig = buf_trig | fifo_trig;
    hold_ce  = ~frame_active;
    state_d  = state_q;
    pause_d  = 1'b0;
    zero_d   = 1'b0;
    if (hold_ce) begin
      case (state_q)
        BP_IDLE: if (any_trig) begin
          state_d = BP_HOLDING;
          pause_d = full_duplex;
        end
        BP_HOLDING: if (!any_trig) begin
          state_d = BP_IDLE;
          pause_d = full_duplex;
          zero_d  = full_duplex;
        end
        default: state_d = BP_IDLE;
      endcase
    end
    coll_d = (state_d == BP_HOLDING) & ~full_duplex;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= BP_IDLE;
      coll       <= 1'b0;
      pause      <= 1'b0;
      pause_zero <= 1'b0;
    end else begin
      state_q    <= state_d;
      coll       <= coll_d;
      pause      <= pause_d;
      pause_zero <= zero_d;
    end
  end

  assign hold = (state_q == BP_HOLDING);

endmodule

// File: rtl/rx_backpressure_ctl.sv
module rx_backpressure_ctl #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned OCC_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*CNT_W-1:0] ch_free_cnt,
  input  logic [NUM_CH*CNT_W-1:0] ch_thresh,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic                    buf_fc_en,
  input  logic                    fifo_fc_en,
  input  logic                    full_duplex,
  input  logic [OCC_W-1:0]        fifo_level,
  input  logic                    fifo_thr_wr,
  input  logic [OCC_W-1:0]        fifo_thr_wdata,
  input  logic                    frame_active,
  output logic                    rx_hold,
  output logic                    coll_req,
  output logic                    pause_req,
  output logic                    pause_zero
);

  logic buf_trig;
  logic fifo_trig;

  rxbp_buf_cmp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .free_cnt (ch_free_cnt),
    .thresh   (ch_thresh),
    .chan_en  (ch_en),
    .enable   (buf_fc_en),
    .trig_q   (buf_trig)
  );

  rxbp_fifo_cmp #(.OCC_W(OCC_W)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .level       (fifo_level),
    .thr_wr      (fifo_thr_wr),
    .thr_wdata   (fifo_thr_wdata),
    .enable      (fifo_fc_en),
    .full_duplex (full_duplex),
    .trig_q      (fifo_trig)
  );

  rxbp_hold_ctl u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .buf_trig     (buf_trig),
    .fifo_trig    (fifo_trig),
    .frame_active (frame_active),
    .full_duplex  (full_duplex),
    .hold         (rx_hold),
    .coll         (coll_req),
    .pause        (pause_req),
    .pause_zero   (pause_zero)
  );

endmodule

// File: rtl/rx_backpressure_ctl_chk.sv
module rx_backpressure_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_active,
  input logic full_duplex,
  input logic rx_hold,
  input logic coll_req,
  input logic pause_req,
  input logic pause_zero
);

  p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |=> $stable(rx_hold));

  p_coll_needs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    coll_req |-> rx_hold);

  p_no_pause_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> $past(full_duplex));

  p_pause_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> !pause_req);

  p_pause_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> (rx_hold != $past(rx_hold)));

  p_zero_on_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && pause_zero) |-> !rx_hold);

  p_zero_qualified_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pause_zero |-> pause_req);

endmodule

bind rx_backpressure_ctl rx_backpressure_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_active (frame_active),
  .full_duplex  (full_duplex),
  .rx_hold      (rx_hold),
  .coll_req     (coll_req),
  .pause_req    (pause_req),
  .pause_zero   (pause_zero)
);

// File: tb/tb_rx_backpressure_ctl.sv
`timescale 1ns/1ps
module tb_rx_backpressure_ctl;

  localparam int NCH = 4;
  localparam int CW  = 4;
  localparam int OW  = 7;

  logic              clk;
  logic              rst_n;
  logic [NCH*CW-1:0] free_v;
  logic [NCH*CW-1:0] thr_v;
  logic [NCH-1:0]    en_v;
  logic              buf_en, fifo_en, fd;
  logic [OW-1:0]     level;
  logic              twr;
  logic [OW-1:0]     twd;
  logic              fa;
  logic              rx_hold, coll_req, pause_req, pause_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rx_backpressure_ctl #(.NUM_CH(NCH), .CNT_W(CW), .OCC_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .ch_free_cnt(free_v), .ch_thresh(thr_v),
    .ch_en(en_v), .buf_fc_en(buf_en), .fifo_fc_en(fifo_en), .full_duplex(fd),
    .fifo_level(level), .fifo_thr_wr(twr), .fifo_thr_wdata(twd),
    .frame_active(fa), .rx_hold(rx_hold), .coll_req(coll_req),
    .pause_req(pause_req), .pause_zero(pause_zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ch(input int i, input int f, input int t);
    free_v[i*CW +: CW] = CW'(f);
    thr_v[i*CW +: CW]  = CW'(t);
  endtask

  task automatic quiet_chs();
    for (int i = 0; i < NCH; i++) set_ch(i, 15, 0);
  endtask

  task automatic wr_thr(input int v);
    twr = 1'b1; twd = OW'(v);
    step(1);
    twr = 1'b0;
  endtask

  function automatic int clampv(input int v);
    if (v < 1) return 1;
    if (v > 66) return 66;
    return v;
  endfunction

  initial begin
    int c;
    int hit;
    rst_n = 1'b0; free_v = '0; thr_v = '0; en_v = '0;
    buf_en = 1'b0; fifo_en = 1'b0; fd = 1'b0; level = '0;
    twr = 1'b0; twd = '0; fa = 1'b0;
    quiet_chs();
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset outputs
    chk("R1 rx_hold", rx_hold, 0);
    chk("R1 coll_req", coll_req, 0);
    chk("R1 pause_req", pause_req, 0);
    // R1: reset threshold of 2 observed through the FIFO trigger
    fd = 1; fifo_en = 1; level = 1; step(3);
    chk("R1 thr2 level1", rx_hold, 0);
    level = 2; step(3);
    chk("R1 thr2 level2", rx_hold, 1);
    level = 0; step(3);
    fifo_en = 0; fd = 0; step(2);

    // R2/R9/R12: sweep channel 0 count and threshold in half duplex
    buf_en = 1; en_v = 4'b0001;
    for (int f = 0; f < 16; f++) begin
      for (int t = 0; t < 16; t++) begin
        set_ch(0, f, t);
        step(2);
        hit = (f <= t) ? 1 : 0;
        chk("R2 sweep hold", rx_hold, hit);
        chk("R9 coll follows", coll_req, hit);
        chk("R9 no pause", pause_req, 0);
      end
    end
    set_ch(0, 15, 0); step(3);

    // R12: latency, one edge is not enough, two are
    set_ch(0, 1, 1); step(1);
    chk("R12 after one edge", rx_hold, 0);
    step(1);
    chk("R12 after two edges", rx_hold, 1);
    set_ch(0, 15, 0); step(3);

    // R2: every channel on its own
    en_v = '1;
    for (int i = 0; i < NCH; i++) begin
      set_ch(i, 3, 3); step(2);
      chk("R2 per channel", rx_hold, 1);
      set_ch(i, 15, 0); step(2);
      chk("R2 per channel clear", rx_hold, 0);
    end

    // R3: disabled channel and disabled buffer trigger ignored
    en_v = 4'b0001;
    set_ch(2, 0, 15); step(3);
    chk("R3 disabled channel", rx_hold, 0);
    set_ch(2, 15, 0);
    buf_en = 0; set_ch(0, 0, 15); step(3);
    chk("R3 buffer trigger disabled", rx_hold, 0);
    set_ch(0, 15, 0); buf_en = 1; step(3);

    // R5: FIFO trigger ignored in half duplex
    fd = 0; fifo_en = 1; level = 100; step(3);
    chk("R5 half duplex fifo", rx_hold, 0);
    chk("R5 no coll", coll_req, 0);
    level = 0; fifo_en = 0; step(3);

    // R4/R6: threshold clamp sweep over every write value
    fd = 1; fifo_en = 1;
    for (int w = 0; w < 128; w++) begin
      wr_thr(w);
      c = clampv(w);
      level = OW'(c - 1); step(3);
      chk("R6 below clamped thr", rx_hold, 0);
      level = OW'(c); step(3);
      chk("R4 at clamped thr", rx_hold, 1);
      level = 127; step(2);
      chk("R4 above thr", rx_hold, 1);
      level = 0; step(3);
    end
    wr_thr(5);

    // R10/R11: pause pulses in full duplex
    level = 5; step(2);
    chk("R10 hold rises", rx_hold, 1);
    chk("R10 pause pulse", pause_req, 1);
    chk("R10 pause not zero", pause_zero, 0);
    chk("R10 no coll", coll_req, 0);
    step(1);
    chk("R10 pulse one cycle", pause_req, 0);
    level = 0; step(2);
    chk("R11 hold falls", rx_hold, 0);
    chk("R11 release pulse", pause_req, 1);
    chk("R11 zero quanta", pause_zero, 1);
    step(1);
    chk("R11 pulse one cycle", pause_req, 0);

    // R8: both triggers, release one at a time
    en_v = 4'b0001;
    set_ch(0, 2, 2); level = 9; step(3);
    chk("R8 both active", rx_hold, 1);
    set_ch(0, 15, 0); step(3);
    chk("R8 fifo still holds", rx_hold, 1);
    level = 0; step(3);
    chk("R8 all clear", rx_hold, 0);

    // R8: buffer clears on the same edge the FIFO engages
    set_ch(0, 2, 2); step(3);
    set_ch(0, 15, 0); level = 9;
    for (int k = 0; k < 4; k++) begin
      step(1);
      chk("R8 swap hold", rx_hold, 1);
      chk("R8 swap no pause", pause_req, 0);
    end
    level = 0; step(3);

    // R7: hold frozen during a frame, moves right after it ends
    fa = 1; level = 9; step(4);
    chk("R7 frozen rise", rx_hold, 0);
    fa = 0; step(1);
    chk("R7 applied at boundary", rx_hold, 1);
    fa = 1; level = 0; step(4);
    chk("R7 frozen fall", rx_hold, 1);
    fa = 0; step(1);
    chk("R7 release at boundary", rx_hold, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule